// File: doc/BRIEF.md
# Ethernet transmit frame builder

This block produces one outgoing Ethernet frame at a time as a serial bit stream, one bit per clock. It takes the frame bytes from a transmit byte FIFO with show-ahead reads: destination and source addresses, length/type and payload, in the order the host wrote them. A per-byte end-of-frame flag marks the last byte. The block waits until the FIFO holds enough bytes and the channel may be used. It then emits the preamble and start delimiter, shifts out the FIFO bytes, adds zero padding to short frames when padding is enabled, and ends with a CRC-32 frame check sequence.

If the FIFO runs dry before the end-of-frame byte has been read, the block ends the frame at once. It sends the complement of the correct check sequence, so every receiver rejects the frame, and it reports the event with its done pulse. Collision handling, deferral timing, line coding and DMA belong to neighbouring blocks.

Top module: `eth_tx_framer`

## Requirements
- R1: A frame starts, with `tx_en` rising, only in the cycle after a cycle in which the FIFO was not empty, `fifo_count >= start_thresh` and `chan_permit` was 1. While any of these is false the block stays idle.
- R2: The first 64 bits of a frame are 62 bits alternating 1,0,1,0,… starting with 1, followed by 1,1. This is seven preamble bytes and one start delimiter.
- R3: Each FIFO byte is popped exactly once and is sent least significant bit first, in FIFO order. `fifo_rd_en` is never asserted while the FIFO is empty.
- R4: With `pad_en`=1, a frame whose last byte arrives before 60 data bytes have been sent is extended with 0x00 bytes up to 60 data bytes. The pad bytes are covered by the FCS.
- R5: With `pad_en`=0, or with 60 or more data bytes, no bytes are added.
- R6: After the data and any pad, 32 FCS bits follow. They are the complement of a CRC-32 register, most significant bit first. The register uses polynomial 0x04C11DB7, is preset to all ones, and is fed every data and pad bit in wire order.
- R7: If the FIFO is empty when the next byte is needed and no end-of-frame byte has been read, the data stops there with no padding. The 32 FCS bits are then the uncomplemented register, which is the inverse of the correct FCS, and `underflow` is 1 together with `done`.
- R8: `tx_en` is 1 without a break from the first preamble bit through the last FCS bit. It is 0 for at least two cycles between frames.
- R9: `done` is a one-cycle pulse in the cycle right after the last FCS bit, the first cycle with `tx_en`=0.
- R10: During reset `tx_en`, `done`, `underflow` and `fifo_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_count | input | CNT_W | Number of bytes held in the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rd_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_last | input | 1 | Head byte is the last byte of its frame |
| fifo_rd_en | output | 1 | Pops the head byte at the clock edge |
| start_thresh | input | CNT_W | Fill level needed before a frame may start |
| chan_permit | input | 1 | Channel may be used now |
| pad_en | input | 1 | Pad short frames to the minimum size |
| tx_bit | output | 1 | Serial transmit data |
| tx_en | output | 1 | Frame in progress on the wire |
| done | output | 1 | One-cycle end-of-frame pulse |
| underflow | output | 1 | With `done`: the frame was cut short by an empty FIFO |

## Verification
Four properties are checked on every cycle:
- the start conditions at each rising `tx_en`;
- a 1 as the first bit on the wire;
- no pop from an empty FIFO;
- the single-cycle `done` and `underflow` pulses and the idle gap after each frame.

The bit content of a frame can only be judged by the bench scenarios. This covers the preamble pattern, byte order, pad insertion, the CRC value and its inversion after an underflow. The bench rebuilds each expected frame from the bytes it pushed and compares it bit for bit, with random lengths, thresholds and padding modes and with directed runts, size boundaries, threshold and permit holds, and an underflow.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam int          PRE_BITS  = 64;
    localparam int          FCS_BITS  = 32;
endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        din,
    output logic [31:0] crc
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init) begin
            crc_d = '1;
        end else if (en) begin
            crc_d = {crc_q[30:0], 1'b0} ^ ((crc_q[31] ^ din) ? CRC_POLY : 32'h0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int MIN_DATA = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_rd_data,
    input  logic             fifo_last,
    output logic             fifo_rd_en,
    input  logic [CNT_W-1:0] start_thresh,
    input  logic             chan_permit,
    input  logic             pad_en,
    output logic             tx_bit,
    output logic             tx_en,
    output logic             done,
    output logic             underflow
);
    localparam int LEN_W = $clog2(MIN_DATA + 1);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_DATA);

    typedef struct packed {
        tx_state_e        st;
        logic [5:0]       cnt;
        logic [7:0]       sh;
        logic             last;
        logic             bad;
        logic [LEN_W-1:0] bytes;
        logic             done;
        logic             uflow;
    } tx_regs_t;

    tx_regs_t    s_d, s_q;
    logic        crc_en;
    logic [31:0] crc;
    logic [LEN_W-1:0] bytes_inc;

    eth_tx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (s_q.st == ST_PRE),
        .en    (crc_en),
        .din   (tx_bit),
        .crc   (crc)
    );

    assign bytes_inc = (s_q.bytes == MIN_LEN) ? s_q.bytes : s_q.bytes + 1'b1;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.uflow  = 1'b0;
        fifo_rd_en = 1'b0;
        tx_bit     = 1'b0;
        crc_en     = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (!fifo_empty && (fifo_count >= start_thresh) && chan_permit) begin
                    s_d.st  = ST_PRE;
                    s_d.cnt = '0;
                end
            end
            ST_PRE: begin
                tx_bit  = (s_q.cnt == 6'(PRE_BITS - 1)) ? 1'b1 : ~s_q.cnt[0];
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == 6'(PRE_BITS - 1)) begin
                    s_d.cnt   = '0;
                    s_d.bytes = '0;
                    s_d.bad   = 1'b0;
                    if (fifo_empty) begin
                        s_d.bad = 1'b1;
                        s_d.st  = ST_FCS;
                    end else begin
                        fifo_rd_en = 1'b1;
                        s_d.sh     = fifo_rd_data;
                        s_d.last   = fifo_last;
                        s_d.st     = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                tx_bit  = s_q.sh[0];
                crc_en  = 1'b1;
                s_d.sh  = {1'b0, s_q.sh[7:1]};
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == 6'd7) begin
                    s_d.cnt   = '0;
                    s_d.bytes = bytes_inc;
                    if (s_q.last) begin
                        s_d.st = (pad_en && (bytes_inc < MIN_LEN)) ? ST_PAD : ST_FCS;
                    end else if (fifo_empty) begin
                        s_d.bad = 1'b1;
                        s_d.st  = ST_FCS;
                    end else begin
                        fifo_rd_en = 1'b1;
                        s_d.sh     = fifo_rd_data;
                        s_d.last   = fifo_last;
                    end
                end
            end
            ST_PAD: begin
                tx_bit  = 1'b0;
                crc_en  = 1'b1;
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == 6'd7) begin
                    s_d.cnt   = '0;
                    s_d.bytes = bytes_inc;
                    if (bytes_inc >= MIN_LEN) s_d.st = ST_FCS;
                end
            end
            ST_FCS: begin
                tx_bit  = crc[5'd31 - s_q.cnt[4:0]] ^ ~s_q.bad;
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == 6'(FCS_BITS - 1)) begin
                    s_d.st    = ST_GAP;
                    s_d.done  = 1'b1;
                    s_d.uflow = s_q.bad;
                end
            end
            ST_GAP: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_en     = (s_q.st == ST_PRE) || (s_q.st == ST_DATA) ||
                       (s_q.st == ST_PAD) || (s_q.st == ST_FCS);
    assign done      = s_q.done;
    assign underflow = s_q.uflow;
endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_empty,
    input logic             fifo_rd_en,
    input logic [CNT_W-1:0] start_thresh,
    input logic             chan_permit,
    input logic             tx_bit,
    input logic             tx_en,
    input logic             done,
    input logic             underflow
);
    assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(!fifo_empty && (fifo_count >= start_thresh) && chan_permit));

    assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> tx_bit);

    assert_no_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);

    assert_uflow_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> done);

    assert_idle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |=> !tx_en);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tx_en && $past(tx_en)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind eth_tx_framer eth_tx_framer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_count   (fifo_count),
    .fifo_empty   (fifo_empty),
    .fifo_rd_en   (fifo_rd_en),
    .start_thresh (start_thresh),
    .chan_permit  (chan_permit),
    .tx_bit       (tx_bit),
    .tx_en        (tx_en),
    .done         (done),
    .underflow    (underflow)
);

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_empty;
    logic [7:0]       fifo_rd_data;
    logic             fifo_last;
    logic             fifo_rd_en;
    logic [CNT_W-1:0] start_thresh = '0;
    logic             chan_permit = 1'b0;
    logic             pad_en = 1'b0;
    logic             tx_bit, tx_en, done, underflow;

    always #4 clk = ~clk;

    eth_tx_framer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
        .fifo_rd_data(fifo_rd_data), .fifo_last(fifo_last), .fifo_rd_en(fifo_rd_en),
        .start_thresh(start_thresh), .chan_permit(chan_permit), .pad_en(pad_en),
        .tx_bit(tx_bit), .tx_en(tx_en), .done(done), .underflow(underflow)
    );

    // FIFO model: pushes from tasks at the falling edge, pops at the rising edge
    logic [7:0] fmem [0:255];
    logic       flast [0:255];
    logic [7:0] wr_ptr = '0;
    logic [7:0] rd_ptr = '0;
    assign fifo_count   = wr_ptr - rd_ptr;
    assign fifo_empty   = (wr_ptr == rd_ptr);
    assign fifo_rd_data = fmem[rd_ptr];
    assign fifo_last    = flast[rd_ptr];
    always @(posedge clk) if (fifo_rd_en) rd_ptr <= rd_ptr + 8'd1;

    // Capture of the wire
    logic cap [0:2047];
    int   ncap = 0;
    always @(negedge clk) if (tx_en) begin
        cap[ncap] = tx_bit;
        ncap = ncap + 1;
    end

    int   checks = 0;
    int   fails = 0;
    logic [7:0] ebyte [0:255];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        fmem[wr_ptr]  = d;
        flast[wr_ptr] = l;
        wr_ptr        = wr_ptr + 8'd1;
    endtask

    function automatic logic [31:0] crc_of(input int nbytes);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < nbytes; b++)
            for (int j = 0; j < 8; j++)
                c = {c[30:0], 1'b0} ^ ((c[31] ^ ebyte[b][j]) ? 32'h04C11DB7 : 32'h0);
        return c;
    endfunction

    task automatic run_frame(input int len, input bit pad, input int thr,
                             input bit uf, input bit slow, input int hold);
        int nd, errs, k, waitc, hi;
        logic [31:0] c;
        start_thresh = CNT_W'(thr);
        pad_en       = pad;
        chan_permit  = (hold == 0);
        ncap         = 0;
        for (int i = 0; i < len; i++) ebyte[i] = 8'($urandom);
        if (slow) begin
            for (int i = 0; i < len; i++) begin
                push(ebyte[i], !uf && (i == len - 1));
                @(negedge clk);
                if (i + 1 < thr)
                    chk(tx_en == 1'b0, "R1", "tx_en below threshold", int'(tx_en), 0);
                else if (i + 1 == thr)
                    chk(tx_en == 1'b1, "R1", "tx_en once threshold met", int'(tx_en), 1);
            end
        end else begin
            for (int i = 0; i < len; i++) push(ebyte[i], !uf && (i == len - 1));
            if (hold > 0) begin
                hi = 0;
                for (int i = 0; i < hold; i++) begin
                    @(negedge clk);
                    if (tx_en) hi++;
                end
                chk(hi == 0, "R1", "tx_en cycles without permit", hi, 0);
                chan_permit = 1'b1;
            end
        end
        waitc = 0;
        while (!done && waitc < 4000) begin
            @(negedge clk);
            waitc++;
        end
        chk(done == 1'b1, "R9", "done seen", int'(done), 1);
        chk(underflow == uf, "R7", "underflow with done", int'(underflow), int'(uf));
        chk(tx_en == 1'b0, "R9", "tx_en low in done cycle", int'(tx_en), 0);
        nd = len;
        if (!uf && pad && len < 60) begin
            for (int i = len; i < 60; i++) ebyte[i] = 8'h00;
            nd = 60;
        end
        chk(ncap == 64 + nd * 8 + 32, "R8", "bits with tx_en high", ncap, 64 + nd * 8 + 32);
        errs = 0;
        for (int i = 0; i < 64; i++)
            if (cap[i] !== ((i == 63) ? 1'b1 : ((i % 2) == 0))) errs++;
        chk(errs == 0, "R2", "preamble bit errors", errs, 0);
        errs = 0;
        for (int b = 0; b < len; b++)
            for (int j = 0; j < 8; j++)
                if (cap[64 + b * 8 + j] !== ebyte[b][j]) errs++;
        chk(errs == 0, "R3", "data bit errors", errs, 0);
        errs = 0;
        for (int b = len; b < nd; b++)
            for (int j = 0; j < 8; j++)
                if (cap[64 + b * 8 + j] !== 1'b0) errs++;
        if (pad) chk(errs == 0, "R4", "pad bit errors", errs, 0);
        else     chk(nd == len, "R5", "data bytes without padding", nd, len);
        c = crc_of(nd);
        if (!uf) c = ~c;
        errs = 0;
        k = 64 + nd * 8;
        for (int i = 0; i < 32; i++)
            if (cap[k + i] !== c[31 - i]) errs++;
        if (uf) chk(errs == 0, "R7", "inverted FCS bit errors", errs, 0);
        else    chk(errs == 0, "R6", "FCS bit errors", errs, 0);
        chk(fifo_empty == 1'b1, "R3", "all pushed bytes popped", int'(fifo_empty), 1);
        @(negedge clk);
        chk(done == 1'b0 && tx_en == 1'b0, "R8", "idle after done",
            int'({done, tx_en}), 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL R8 watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int len, thr;
        bit pad;
        void'($urandom(32'd20240611));
        repeat (3) begin
            @(negedge clk);
            chk(tx_en == 1'b0 && done == 1'b0 && underflow == 1'b0 && fifo_rd_en == 1'b0,
                "R10", "outputs in reset", int'({tx_en, done, underflow, fifo_rd_en}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_en == 1'b0, "R10", "tx_en after reset", int'(tx_en), 0);

        run_frame(1,  1'b1, 1, 1'b0, 1'b0, 0);   // R4: single byte padded to 60
        run_frame(59, 1'b1, 4, 1'b0, 1'b0, 0);   // R4: one pad byte
        run_frame(60, 1'b1, 4, 1'b0, 1'b0, 0);   // R5: at minimum, no pad
        run_frame(61, 1'b1, 4, 1'b0, 1'b0, 0);   // R5: above minimum
        run_frame(10, 1'b0, 2, 1'b0, 1'b0, 0);   // R5: runt left short
        run_frame(12, 1'b1, 8, 1'b0, 1'b1, 0);   // R1: fill threshold
        run_frame(20, 1'b0, 3, 1'b0, 1'b0, 30);  // R1: permit held low
        run_frame(5,  1'b1, 3, 1'b1, 1'b0, 0);   // R7: underflow, no pad
        run_frame(14, 1'b0, 6, 1'b1, 1'b1, 0);   // R7: underflow after slow fill
        for (int n = 0; n < 25; n++) begin
            len = 1 + int'($urandom % 90);
            pad = 1'($urandom);
            thr = 1 + int'($urandom % ((len < 16) ? len : 16));
            run_frame(len, pad, thr, 1'b0, 1'b0, 0);  // R3 R6 random frames
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule